// File: doc/BRIEF.md
# USB Root Hub Port Register File

This block holds the root-hub power control and the per-port status and change registers of a host controller of the open register style. Software reaches it through a byte-wide write strobe with an address and a data byte; every register is also presented on output ports for readback. Each downstream port keeps its power, connect, enable and suspend state, plus a change byte whose bits software clears by writing ones.

Writes to a port's command byte are commands rather than stored values. Their effect depends on whether a device is connected to that port: an enable or reset request on an empty port only raises the connect-change flag. Port power is set by a power-switching mode, by a per-port power-control mask, and by global set and clear strobes. A device-attach input per port models a device being plugged in.

Port reset completes at once, and the overcurrent flag is never raised. The reset duration and the overcurrent detection are not modelled.

Top module: `rh_root_hub_regs`

## Requirements
- R1: After synchronous reset every readback output is zero and every port is unpowered.
- R2: A write to address 0 (mode byte) stores data AND 0x1B, and the power mode is bits 1:0 of that byte. A write to address 1 (mask byte) stores only bits 1..NUM_PORTS, where bit p+1 is the power-control mask of port p. All other stored bits read zero.
- R3: A mode-byte write with data bit 1 set powers every port in the next cycle.
- R4: A write to address 2 with bit 0 set removes power in the following cases: from every port in mode 00, and in mode 01 from each port whose mask bit is clear. Each port hit this way also has its connect, enable and suspend bits cleared, and its change bits 0, 1, 2 and 4 cleared. In modes 10 and 11 the write has no effect.
- R5: A write to address 3 with bit 0 set powers the same selection of ports as R4 and leaves their other state alone.
- R6: Port p's power byte is at address 5+4p. Data bit 1 clears power, with the clearing effects of R4. Data bit 0 sets power. Both act only when the stored mode is 00 and the port's mask bit is set. When both bits are set, the port ends powered with its status cleared.
- R7: When attach[p] is high, the connect bit (status bit 0) and the connect-change bit (change bit 0) are set, but only if the port is powered at the end of that cycle. An unpowered port ignores attach.
- R8: Port p's command byte is at address 4+4p. On a connected port, bit 1 sets enable (status bit 1) and bit 0 clears it; when both are written, clear wins. On an unconnected port, either bit sets the connect-change bit instead.
- R9: Command bit 4 (port reset) on a connected port sets reset-change (change bit 4). On an unconnected port it sets connect-change instead. Status bit 4 always reads 0.
- R10: Command bit 2 sets suspend (status bit 2) and bit 3 clears it; when both are written, set wins. Suspend going from 1 to 0 sets suspend-change (change bit 2).
- R11: Port p's change byte is at address 6+4p. A write there clears every change bit whose data bit is 1, within mask 0x1F.
- R12: A port's enable bit is never 1 unless its connect bit is 1. An unpowered port never reads connected.
- R13: Cycles without wr_en, and writes to unmapped addresses (7, 11 to 15), change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Write data |
| attach | input | NUM_PORTS | Device attach event per port |
| mode_o | output | 8 | Stored mode byte |
| mask_o | output | 8 | Stored power-control mask byte |
| port_power_o | output | NUM_PORTS | Power state per port |
| port_status_o | output | 8*NUM_PORTS | Status byte per port, port p at bits 8p+7:8p |
| port_change_o | output | 8*NUM_PORTS | Change byte per port, port p at bits 8p+7:8p |

## Verification
The bench builds the block with its defaults, NUM_PORTS = 2 and ADDR_W = 4. With these values a 4-bit random address covers every mapped register of both ports as well as the unmapped holes, so random traffic reaches every register. Random mode and mask values then run all four power modes against both mask settings. Directed steps set up the interactions that random traffic seldom reaches: a command on an empty port, a suspend that falls, a port-power write in a masked mode, and an attach to an unpowered port.

// File: rtl/rh_pkg.sv
package rh_pkg;

    // Power switching mode held in bits 1:0 of the mode byte
    typedef enum logic [1:0] {
        PSW_GANGED   = 2'b00,
        PSW_PER_PORT = 2'b01,
        PSW_FIXED    = 2'b10,
        PSW_FIXED_B  = 2'b11
    } psw_mode_e;

    // Live state of one port
    typedef struct packed {
        logic pwr;
        logic susp;
        logic en;
        logic conn;
    } port_state_t;

    // Change flags of one port, bit order equals change byte bits 4:0
    typedef struct packed {
        logic rst;
        logic oc;
        logic susp;
        logic en;
        logic conn;
    } port_chg_t;

    localparam logic [7:0] MODE_WMASK   = 8'h1B;
    localparam logic [4:0] CHG_W1C_MASK = 5'h1F;

    localparam int HUB_MODE_OFS = 0;
    localparam int HUB_MASK_OFS = 1;
    localparam int HUB_CLR_OFS  = 2;
    localparam int HUB_SET_OFS  = 3;
    localparam int PORT_BASE    = 4;
    localparam int PORT_STRIDE  = 4;
    localparam int PORT_CMD_REL = 0;
    localparam int PORT_PWR_REL = 1;
    localparam int PORT_CHG_REL = 2;

    function automatic int port_addr(int p, int rel);
        return PORT_BASE + PORT_STRIDE * p + rel;
    endfunction

    // Writable bits of the mask byte: bit p+1 for each port p
    function automatic logic [7:0] mask_wmask(int n);
        logic [7:0] m;
        m = '0;
        for (int i = 0; i < n; i++) m[i+1] = 1'b1;
        return m;
    endfunction

    function automatic logic [7:0] status_byte(port_state_t s);
        return {5'b0, s.susp, s.en, s.conn};
    endfunction

    function automatic logic [7:0] change_byte(port_chg_t c);
        return {3'b0, c};
    endfunction

    // Is a port affected by the global set and clear strobes
    function automatic logic global_sel(psw_mode_e m, logic masked);
        return (m == PSW_GANGED) || ((m == PSW_PER_PORT) && !masked);
    endfunction

endpackage

// File: rtl/rh_addr_dec.sv
module rh_addr_dec
    import rh_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 4
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    output logic                 hit_mode,
    output logic                 hit_mask,
    output logic                 hit_clr,
    output logic                 hit_set,
    output logic [NUM_PORTS-1:0] hit_cmd,
    output logic [NUM_PORTS-1:0] hit_pwr,
    output logic [NUM_PORTS-1:0] hit_chg
);

    always_comb begin
        hit_mode = wr_en && (wr_addr == ADDR_W'(HUB_MODE_OFS));
        hit_mask = wr_en && (wr_addr == ADDR_W'(HUB_MASK_OFS));
        hit_clr  = wr_en && (wr_addr == ADDR_W'(HUB_CLR_OFS));
        hit_set  = wr_en && (wr_addr == ADDR_W'(HUB_SET_OFS));
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_dec
        localparam int CMD_A = port_addr(p, PORT_CMD_REL);
        localparam int PWR_A = port_addr(p, PORT_PWR_REL);
        localparam int CHG_A = port_addr(p, PORT_CHG_REL);
        assign hit_cmd[p] = wr_en && (wr_addr == ADDR_W'(CMD_A));
        assign hit_pwr[p] = wr_en && (wr_addr == ADDR_W'(PWR_A));
        assign hit_chg[p] = wr_en && (wr_addr == ADDR_W'(CHG_A));
    end

endmodule

// File: rtl/rh_hub_ctrl.sv
module rh_hub_ctrl
    import rh_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hit_mode,
    input  logic                 hit_mask,
    input  logic                 hit_clr,
    input  logic                 hit_set,
    input  logic [NUM_PORTS-1:0] hit_pwr,
    input  logic [7:0]           wr_data,
    output logic [7:0]           mode_o,
    output logic [7:0]           mask_o,
    output logic [NUM_PORTS-1:0] pwr_on,
    output logic [NUM_PORTS-1:0] pwr_off
);

    localparam logic [7:0] MASK_WMASK = mask_wmask(NUM_PORTS);

    logic [7:0] mode_q;
    logic [7:0] mask_q;
    psw_mode_e  mode_cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            mask_q <= '0;
        end else begin
            if (hit_mode) mode_q <= wr_data & MODE_WMASK;
            if (hit_mask) mask_q <= wr_data & MASK_WMASK;
        end
    end

    assign mode_cur = psw_mode_e'(mode_q[1:0]);
    assign mode_o   = mode_q;
    assign mask_o   = mask_q;

    // Power requests use the mode and mask held before this write
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pwr_req
        logic sel_glob;
        logic own_ok;
        always_comb begin
            sel_glob   = global_sel(mode_cur, mask_q[p+1]);
            own_ok     = (mode_cur == PSW_GANGED) && mask_q[p+1];
            pwr_off[p] = (hit_clr && wr_data[0] && sel_glob)
                       || (hit_pwr[p] && wr_data[1] && own_ok);
            pwr_on[p]  = (hit_set && wr_data[0] && sel_glob)
                       || (hit_mode && wr_data[1])
                       || (hit_pwr[p] && wr_data[0] && own_ok);
        end
    end

endmodule

// File: rtl/rh_port.sv
module rh_port
    import rh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic       chg_wr,
    input  logic [4:0] wr_bits,
    input  logic       pwr_on,
    input  logic       pwr_off,
    input  logic       attach,
    output logic       powered,
    output logic [7:0] status_o,
    output logic [7:0] change_o
);

    port_state_t st_q, st_n;
    port_chg_t   ch_q, ch_n;

    always_comb begin
        st_n = st_q;
        ch_n = ch_q;

        // Command byte: each request is judged on the connect state before the write
        if (cmd_wr) begin
            if (wr_bits[4]) begin
                if (st_q.conn) ch_n.rst = 1'b1;
                else           ch_n.conn = 1'b1;
            end
            if (wr_bits[3]) st_n.susp = 1'b0;
            if (wr_bits[2]) st_n.susp = 1'b1;
            if (wr_bits[1]) begin
                if (st_q.conn) st_n.en = 1'b1;
                else           ch_n.conn = 1'b1;
            end
            if (wr_bits[0]) begin
                if (st_q.conn) st_n.en = 1'b0;
                else           ch_n.conn = 1'b1;
            end
            if (st_q.susp && !st_n.susp) ch_n.susp = 1'b1;
        end

        if (chg_wr) ch_n = port_chg_t'(ch_n & ~(wr_bits & CHG_W1C_MASK));

        // Losing power drops the link state and its flags, overcurrent excepted
        if (pwr_off) begin
            st_n.pwr  = 1'b0;
            st_n.conn = 1'b0;
            st_n.en   = 1'b0;
            st_n.susp = 1'b0;
            ch_n.conn = 1'b0;
            ch_n.en   = 1'b0;
            ch_n.susp = 1'b0;
            ch_n.rst  = 1'b0;
        end
        if (pwr_on) st_n.pwr = 1'b1;

        if (attach && st_n.pwr) begin
            st_n.conn = 1'b1;
            ch_n.conn = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            ch_q <= '0;
        end else begin
            st_q <= st_n;
            ch_q <= ch_n;
        end
    end

    assign powered  = st_q.pwr;
    assign status_o = status_byte(st_q);
    assign change_o = change_byte(ch_q);

endmodule

// File: rtl/rh_root_hub_regs.sv
module rh_root_hub_regs
    import rh_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    input  logic [NUM_PORTS-1:0]   attach,
    output logic [7:0]             mode_o,
    output logic [7:0]             mask_o,
    output logic [NUM_PORTS-1:0]   port_power_o,
    output logic [8*NUM_PORTS-1:0] port_status_o,
    output logic [8*NUM_PORTS-1:0] port_change_o
);

    logic                 hit_mode, hit_mask, hit_clr, hit_set;
    logic [NUM_PORTS-1:0] hit_cmd, hit_pwr, hit_chg;
    logic [NUM_PORTS-1:0] pwr_on, pwr_off;

    rh_addr_dec #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .hit_mode (hit_mode),
        .hit_mask (hit_mask),
        .hit_clr  (hit_clr),
        .hit_set  (hit_set),
        .hit_cmd  (hit_cmd),
        .hit_pwr  (hit_pwr),
        .hit_chg  (hit_chg)
    );

    rh_hub_ctrl #(
        .NUM_PORTS (NUM_PORTS)
    ) u_hub (
        .clk      (clk),
        .rst      (rst),
        .hit_mode (hit_mode),
        .hit_mask (hit_mask),
        .hit_clr  (hit_clr),
        .hit_set  (hit_set),
        .hit_pwr  (hit_pwr),
        .wr_data  (wr_data),
        .mode_o   (mode_o),
        .mask_o   (mask_o),
        .pwr_on   (pwr_on),
        .pwr_off  (pwr_off)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rh_port u_port (
            .clk      (clk),
            .rst      (rst),
            .cmd_wr   (hit_cmd[p]),
            .chg_wr   (hit_chg[p]),
            .wr_bits  (wr_data[4:0]),
            .pwr_on   (pwr_on[p]),
            .pwr_off  (pwr_off[p]),
            .attach   (attach[p]),
            .powered  (port_power_o[p]),
            .status_o (port_status_o[8*p +: 8]),
            .change_o (port_change_o[8*p +: 8])
        );
    end

endmodule

// File: rtl/rh_root_hub_checker.sv
module rh_root_hub_checker
    import rh_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      wr_addr,
    input logic [7:0]             wr_data,
    input logic [NUM_PORTS-1:0]   attach,
    input logic [7:0]             mode_o,
    input logic [7:0]             mask_o,
    input logic [NUM_PORTS-1:0]   port_power_o,
    input logic [8*NUM_PORTS-1:0] port_status_o,
    input logic [8*NUM_PORTS-1:0] port_change_o
);

    // R2: mode byte keeps only its writable bits
    a_r2_mode_store: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(HUB_MODE_OFS))
        |=> (mode_o == ($past(wr_data) & MODE_WMASK)));

    // R3: mode write with bit 1 powers all ports
    a_r3_mode_powers_all: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(HUB_MODE_OFS) && wr_data[1])
        |=> (&port_power_o));

    // R4: global clear does nothing when switching is off (mode 1x)
    a_r4_fixed_mode_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(HUB_CLR_OFS) && mode_o[1])
        |=> $stable(port_power_o));

    // R13: idle cycles leave every register unchanged
    a_r13_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && attach == '0)
        |=> ($stable(mode_o) && $stable(mask_o) && $stable(port_power_o)
             && $stable(port_status_o) && $stable(port_change_o)));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        localparam int CHG_A = port_addr(p, PORT_CHG_REL);

        // R12: enable implies connect
        a_r12_enable_needs_conn: assert property (@(posedge clk) disable iff (rst)
            port_status_o[8*p+1] |-> port_status_o[8*p]);

        // R12: unpowered port is never connected
        a_r12_unpowered_idle: assert property (@(posedge clk) disable iff (rst)
            !port_power_o[p] |-> !port_status_o[8*p]);

        // R11: written ones clear the change bits
        a_r11_w1c: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == ADDR_W'(CHG_A) && !attach[p])
            |=> ((port_change_o[8*p +: 5] & $past(wr_data[4:0])) == 5'd0));

        // R7: attach on a powered port with no write raises connect and its flag
        a_r7_attach_connects: assert property (@(posedge clk) disable iff (rst)
            (attach[p] && !wr_en && port_power_o[p])
            |=> (port_status_o[8*p] && port_change_o[8*p]));
    end

endmodule

bind rh_root_hub_regs rh_root_hub_checker #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W)
) u_rh_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .attach        (attach),
    .mode_o        (mode_o),
    .mask_o        (mask_o),
    .port_power_o  (port_power_o),
    .port_status_o (port_status_o),
    .port_change_o (port_change_o)
);

// File: tb/rh_root_hub_regs_bench.sv
module rh_root_hub_regs_bench;

    localparam int NP = 2;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [NP-1:0] attach = '0;
    logic [7:0]    mode_o, mask_o;
    logic [NP-1:0] port_power_o;
    logic [8*NP-1:0] port_status_o, port_change_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model
    logic [7:0] m_mode, m_mask;
    logic       m_pwr [NP];
    logic       m_conn[NP];
    logic       m_en  [NP];
    logic       m_susp[NP];
    logic [4:0] m_chg [NP];

    always #10 clk = ~clk;

    rh_root_hub_regs #(.NUM_PORTS(NP), .ADDR_W(AW)) u_rh_root_hub_regs (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .attach        (attach),
        .mode_o        (mode_o),
        .mask_o        (mask_o),
        .port_power_o  (port_power_o),
        .port_status_o (port_status_o),
        .port_change_o (port_change_o)
    );

    function automatic void model_reset();
        m_mode = '0;
        m_mask = '0;
        for (int p = 0; p < NP; p++) begin
            m_pwr[p] = 0; m_conn[p] = 0; m_en[p] = 0; m_susp[p] = 0; m_chg[p] = '0;
        end
    endfunction

    function automatic void model_step(logic en, logic [3:0] a, logic [7:0] d, logic [NP-1:0] att);
        logic [1:0] md;
        md = m_mode[1:0];
        for (int p = 0; p < NP; p++) begin
            logic sel, own, on, off, oc, os;
            sel = (md == 2'b00) || (md == 2'b01 && !m_mask[p+1]);
            own = (md == 2'b00) && m_mask[p+1];
            on  = en && ((a == 4'd3 && d[0] && sel) || (a == 4'd0 && d[1]) ||
                         (a == 4'(5 + 4*p) && d[0] && own));
            off = en && ((a == 4'd2 && d[0] && sel) ||
                         (a == 4'(5 + 4*p) && d[1] && own));
            oc = m_conn[p];
            os = m_susp[p];
            if (en && a == 4'(4 + 4*p)) begin
                if (d[4]) begin if (oc) m_chg[p][4] = 1; else m_chg[p][0] = 1; end
                if (d[3]) m_susp[p] = 0;
                if (d[2]) m_susp[p] = 1;
                if (d[1]) begin if (oc) m_en[p] = 1; else m_chg[p][0] = 1; end
                if (d[0]) begin if (oc) m_en[p] = 0; else m_chg[p][0] = 1; end
                if (os && !m_susp[p]) m_chg[p][2] = 1;
            end
            if (en && a == 4'(6 + 4*p)) m_chg[p] = m_chg[p] & ~d[4:0];
            if (off) begin
                m_pwr[p] = 0; m_conn[p] = 0; m_en[p] = 0; m_susp[p] = 0;
                m_chg[p] = m_chg[p] & 5'b01000;
            end
            if (on) m_pwr[p] = 1;
            if (att[p] && m_pwr[p]) begin
                m_conn[p] = 1;
                m_chg[p][0] = 1;
            end
        end
        if (en && a == 4'd0) m_mode = d & 8'h1B;
        if (en && a == 4'd1) m_mask = d & 8'h06;
    endfunction

    task automatic fail_line(string tag, string what, logic [15:0] got, logic [15:0] exp);
        failures++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    endtask

    task automatic check_all(string tag);
        logic [NP-1:0] ep;
        logic [8*NP-1:0] es, ec;
        logic bad;
        checks++;
        for (int p = 0; p < NP; p++) begin
            ep[p] = m_pwr[p];
            es[8*p +: 8] = {5'b0, m_susp[p], m_en[p], m_conn[p]};
            ec[8*p +: 8] = {3'b0, m_chg[p]};
        end
        bad = 0;
        if (mode_o !== m_mode) begin fail_line(tag, "mode", 16'(mode_o), 16'(m_mode)); bad = 1; end
        if (mask_o !== m_mask) begin fail_line(tag, "mask", 16'(mask_o), 16'(m_mask)); bad = 1; end
        if (port_power_o !== ep) begin fail_line(tag, "power", 16'(port_power_o), 16'(ep)); bad = 1; end
        if (port_status_o !== es) begin fail_line(tag, "status", 16'(port_status_o), 16'(es)); bad = 1; end
        if (port_change_o !== ec) begin fail_line(tag, "change", 16'(port_change_o), 16'(ec)); bad = 1; end
        // R12 invariant observed at the ports
        for (int p = 0; p < NP; p++) begin
            if (!bad && ((port_status_o[8*p+1] && !port_status_o[8*p]) ||
                         (!port_power_o[p] && port_status_o[8*p])))
                fail_line("R12", "invariant", 16'(port_status_o), 16'(es));
        end
    endtask

    task automatic step(logic en, logic [3:0] a, logic [7:0] d, logic [NP-1:0] att);
        wr_en = en; wr_addr = a; wr_data = d; attach = att;
        model_step(en, a, d, att);
        @(negedge clk);
        wr_en = 0; attach = '0;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        step(1'b1, a, d, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        check_all("R1");

        wr(4'd1, 8'hFF);           check_all("R2");
        wr(4'd0, 8'hFF);           check_all("R3");
        wr(4'd0, 8'h00);           check_all("R2");
        wr(4'd2, 8'h01);           check_all("R4");
        wr(4'd3, 8'h01);           check_all("R5");
        step(1'b0, 4'd0, 8'h00, 2'b01); check_all("R7");
        wr(4'd4, 8'h02);           check_all("R8");
        wr(4'd8, 8'h02);           check_all("R8");
        wr(4'd4, 8'h03);           check_all("R8");
        wr(4'd4, 8'h10);           check_all("R9");
        wr(4'd4, 8'h04);           check_all("R10");
        wr(4'd4, 8'h08);           check_all("R10");
        wr(4'd4, 8'h0C);           check_all("R10");
        wr(4'd6, 8'h1F);           check_all("R11");
        wr(4'd10, 8'h01);          check_all("R11");
        wr(4'd5, 8'h02);           check_all("R6");
        wr(4'd5, 8'h01);           check_all("R6");
        step(1'b0, 4'd0, 8'h00, 2'b01); check_all("R7");
        wr(4'd5, 8'h03);           check_all("R6");
        wr(4'd0, 8'h01);           check_all("R2");
        wr(4'd1, 8'h02);           check_all("R2");
        wr(4'd2, 8'h01);           check_all("R4");
        wr(4'd3, 8'h01);           check_all("R5");
        wr(4'd9, 8'h02);           check_all("R6");
        wr(4'd0, 8'h02);           check_all("R3");
        wr(4'd2, 8'h01);           check_all("R4");
        wr(4'd0, 8'h00);
        wr(4'd2, 8'h01);           check_all("R4");
        step(1'b0, 4'd0, 8'h00, 2'b11); check_all("R7");
        wr(4'd8, 8'h10);           check_all("R9");
        wr(4'd15, 8'hFF);          check_all("R13");
        wr(4'd7, 8'hFF);           check_all("R13");
        step(1'b0, 4'd4, 8'hFF, 2'b00); check_all("R13");

        seed = $urandom(32'h0005EED5);
        for (int i = 0; i < 4000; i++) begin
            logic en;
            logic [3:0] a;
            logic [7:0] d;
            logic [NP-1:0] att;
            en = ($urandom_range(0, 9) < 8);
            a  = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0) a = 4'($urandom_range(0, 2));
            d  = 8'($urandom());
            for (int p = 0; p < NP; p++) att[p] = ($urandom_range(0, 9) == 0);
            step(en, a, d, att);
            check_all("R13 random mix");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule